// File: doc/BRIEF.md
# Dual-role SPI serial port

This block is a byte-wide synchronous serial port that can act either as the clock-driving master of an SPI link or as a device that follows an external serial clock. A single control register holds the enable, the resting level of the serial clock, a four-bit mode code and two sticky error flags. Software loads an outgoing byte through a buffer-write strobe and collects each incoming byte from a receive buffer, whose `buf_full` status tells it that a byte is waiting.

As master, a buffer write starts an eight-bit exchange, with the serial clock derived from the system clock by a divider or from an external timer pulse. As a follower, the serial clock arrives on an input pin and is brought into the system clock domain by a two-stage synchroniser and an edge detector. A chip-select input can gate the follower, or it can be ignored. Output enables for the clock and data pins let the surrounding pad logic hand the pins back to general use when the port is off.

Top module: `spi_port`

## Requirements
- R1: After reset the control register reads 0x00, `buf_full` is 0, and `sck_oe`, `sdo_oe` and `port_en` are all 0.
- R2: In master mode the serial clock period is 4 system clocks for mode 0000, 16 for mode 0001 and 64 for mode 0010. For mode 0011 it is two `tmr_pulse` intervals.
- R3: Control bit 4 sets the idle level of SCK. The leading edge is the edge that leaves the idle level, and SDI is sampled on it. SDO changes on the trailing edge. Data travels MSB first.
- R4: When the eighth bit completes, the received byte appears on `buf_rdata` and `buf_full` rises. A `buf_rd` pulse clears `buf_full`.
- R5: A buffer write while a transfer is in progress sets control bit 7 (write collision). That write is discarded, so the transfer in flight completes with its original byte.
- R6: In follower modes (0100, 0101), a byte that completes while `buf_full` is set raises control bit 6 (overflow). The new byte is dropped, and the buffer keeps the earlier byte.
- R7: In master modes, control bit 6 is never set by hardware. Each completed byte overwrites the buffer.
- R8: Control bits 7 and 6 stay set until a control write stores 0 into them.
- R9: With control bit 5 at 0, `port_en`, `sck_oe` and `sdo_oe` are 0, and a buffer write starts no transfer.
- R10: In mode 0100, a high `ss_n_i` releases SDO (`sdo_oe`=0) and discards any partly received bits. The next byte is then framed from its first bit.
- R11: In mode 0101, `ss_n_i` is ignored: SDO is driven and bytes are received while `ss_n_i` is high.
- R12: Mode codes other than 0000 to 0101 leave the pins released and start no transfer, even when control bit 5 is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| tmr_pulse | input | 1 | Single-cycle timer pulse used as the master clock source in mode 0011 |
| ctl_wr | input | 1 | Write strobe for the control register |
| ctl_wdata | input | 8 | Control write data: [7] collision, [6] overflow, [5] enable, [4] idle level, [3:0] mode |
| ctl_rdata | output | 8 | Control register contents |
| buf_wr | input | 1 | Load strobe for the transmit byte |
| buf_wdata | input | 8 | Byte to transmit |
| buf_rd | input | 1 | Acknowledges the received byte; clears `buf_full` |
| buf_rdata | output | 8 | Last accepted received byte |
| buf_full | output | 1 | Received byte waiting |
| port_en | output | 1 | Pins are owned by the port (enabled in a valid mode) |
| sck_i | input | 1 | Serial clock from the pin (follower modes) |
| sck_o | output | 1 | Serial clock to the pin (master modes) |
| sck_oe | output | 1 | Drive enable for the clock pin |
| sdi_i | input | 1 | Serial data in |
| sdo_o | output | 1 | Serial data out |
| sdo_oe | output | 1 | Drive enable for the data-out pin |
| ss_n_i | input | 1 | Active-low chip select (follower mode 0100) |

## Verification
The bench measures the SCK period for each of the four master clock sources and for both idle levels. A divider that miscounts by one half-period, or a polarity swap, shows up as a wrong cycle count or a wrong idle level. A write in the middle of a transfer must set the collision flag and leave the byte on the wire unchanged; a design that reloads the shifter would return the second byte over the loopback. Two follower receptions without a read must raise overflow and keep the first byte, and a design that overwrites the buffer fails that check. The bench also drops chip select after three bits: a design that keeps the stale bit count would frame the next byte wrongly.

// File: rtl/spi_port_pkg.sv
package spi_port_pkg;
  localparam int DATA_W   = 8;
  localparam int MAX_HALF = 32;
  localparam int HALF_W   = $clog2(MAX_HALF) + 1;

  localparam logic [3:0] MD_FAST  = 4'b0000;
  localparam logic [3:0] MD_MID   = 4'b0001;
  localparam logic [3:0] MD_SLOW  = 4'b0010;
  localparam logic [3:0] MD_TIMER = 4'b0011;
  localparam logic [3:0] MD_FOL_S = 4'b0100;
  localparam logic [3:0] MD_FOL_F = 4'b0101;

  // system clocks per SCK half period for the divider-based master modes
  function automatic logic [HALF_W-1:0] half_period(input logic [3:0] m);
    case (m[1:0])
      2'd0:    return HALF_W'(2);
      2'd1:    return HALF_W'(8);
      default: return HALF_W'(MAX_HALF);
    endcase
  endfunction

  function automatic logic is_master(input logic [3:0] m);
    return m[3:2] == 2'b00;
  endfunction

  function automatic logic is_follower(input logic [3:0] m);
    return (m == MD_FOL_S) || (m == MD_FOL_F);
  endfunction
endpackage

// File: rtl/spi_port_sync.sv
module spi_port_sync #(
  parameter int W = 1,
  parameter logic [W-1:0] RST = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta <= RST;
      q    <= RST;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/spi_port_clkgen.sv
module spi_port_clkgen
  import spi_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              run,
  input  logic              use_tmr,
  input  logic              tmr_pulse,
  input  logic [HALF_W-1:0] half,
  output logic              tick
);
  logic [HALF_W-1:0] cnt;
  logic              wrap;

  assign wrap = (cnt == half - HALF_W'(1));
  assign tick = run && (use_tmr ? tmr_pulse : wrap);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)            cnt <= '0;
    else if (!run)         cnt <= '0;
    else if (!use_tmr)     cnt <= wrap ? '0 : cnt + HALF_W'(1);
  end
endmodule

// File: rtl/spi_port_shifter.sv
module spi_port_shifter #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          clear,
  input  logic          lead,
  input  logic          trail,
  input  logic          load,
  input  logic [DW-1:0] load_data,
  input  logic          sdi,
  output logic          sdo,
  output logic          active,
  output logic          done,
  output logic [DW-1:0] rx_data
);
  localparam int CW = $clog2(DW + 1);

  logic [DW-1:0] sr;
  logic          rx_bit;
  logic          led;
  logic [CW-1:0] cnt;
  logic          shift;

  assign shift   = trail && led;
  assign done    = shift && (cnt == CW'(DW - 1));
  assign rx_data = {sr[DW-2:0], rx_bit};
  assign sdo     = sr[DW-1];
  assign active  = led || (cnt != '0);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sr     <= '0;
      rx_bit <= 1'b0;
      led    <= 1'b0;
      cnt    <= '0;
    end else if (clear) begin
      led <= 1'b0;
      cnt <= '0;
    end else begin
      if (load) sr <= load_data;
      if (lead) begin
        rx_bit <= sdi;
        led    <= 1'b1;
      end else if (shift) begin
        sr  <= {sr[DW-2:0], rx_bit};
        led <= 1'b0;
        cnt <= done ? '0 : cnt + CW'(1);
      end
    end
  end
endmodule

// File: rtl/spi_port.sv
module spi_port
  import spi_port_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tmr_pulse,
  input  logic              ctl_wr,
  input  logic [7:0]        ctl_wdata,
  output logic [7:0]        ctl_rdata,
  input  logic              buf_wr,
  input  logic [DATA_W-1:0] buf_wdata,
  input  logic              buf_rd,
  output logic [DATA_W-1:0] buf_rdata,
  output logic              buf_full,
  output logic              port_en,
  input  logic              sck_i,
  output logic              sck_o,
  output logic              sck_oe,
  input  logic              sdi_i,
  output logic              sdo_o,
  output logic              sdo_oe,
  input  logic              ss_n_i
);
  // control fields
  logic       f_wcol, f_ovf, f_en, f_ckp;
  logic [3:0] f_mode;

  // named internal events
  logic master_m, slave_m, en_ok, xfer_active, wr_ok, set_wcol, set_ovf, store;
  logic m_busy, m_tick, sck_lvl;
  logic sck_s, ss_s, sck_p, s_edge, ss_ok, sh_clear;
  logic lead, trail, sh_active, rx_done, sh_sdo;
  logic [DATA_W-1:0] rx_data, rxbuf;

  assign master_m    = is_master(f_mode);
  assign slave_m     = is_follower(f_mode);
  assign en_ok       = f_en && (master_m || slave_m);
  assign xfer_active = en_ok && (master_m ? m_busy : sh_active);
  assign wr_ok       = buf_wr && en_ok && !xfer_active;
  assign set_wcol    = buf_wr && en_ok && xfer_active;
  assign set_ovf     = rx_done && slave_m && buf_full && !buf_rd;
  assign store       = rx_done && !set_ovf;

  spi_port_sync #(.W(2), .RST(2'b01)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({sck_i, ss_n_i}), .q({sck_s, ss_s})
  );

  spi_port_clkgen u_clk (
    .clk(clk), .rst_n(rst_n), .run(m_busy), .use_tmr(f_mode == MD_TIMER),
    .tmr_pulse(tmr_pulse), .half(half_period(f_mode)), .tick(m_tick)
  );

  assign s_edge   = (sck_s != sck_p);
  assign ss_ok    = (f_mode == MD_FOL_F) || !ss_s;
  assign sh_clear = !en_ok || ((f_mode == MD_FOL_S) && ss_s);
  assign lead     = master_m ? (m_tick && sck_lvl == f_ckp)
                             : (s_edge && ss_ok && sck_p == f_ckp);
  assign trail    = master_m ? (m_tick && sck_lvl != f_ckp)
                             : (s_edge && ss_ok && sck_p != f_ckp);

  spi_port_shifter #(.DW(DATA_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .clear(sh_clear), .lead(lead), .trail(trail),
    .load(wr_ok), .load_data(buf_wdata), .sdi(sdi_i), .sdo(sh_sdo),
    .active(sh_active), .done(rx_done), .rx_data(rx_data)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      f_wcol <= 1'b0; f_ovf <= 1'b0; f_en <= 1'b0; f_ckp <= 1'b0;
      f_mode <= '0;
    end else begin
      if (ctl_wr) begin
        f_wcol <= ctl_wdata[7] | set_wcol;
        f_ovf  <= ctl_wdata[6] | set_ovf;
        f_en   <= ctl_wdata[5];
        f_ckp  <= ctl_wdata[4];
        f_mode <= ctl_wdata[3:0];
      end else begin
        f_wcol <= f_wcol | set_wcol;
        f_ovf  <= f_ovf | set_ovf;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_busy  <= 1'b0;
      sck_lvl <= 1'b0;
      sck_p   <= 1'b0;
    end else begin
      sck_p <= sck_s;
      if (!en_ok || !master_m)  m_busy <= 1'b0;
      else if (wr_ok)           m_busy <= 1'b1;
      else if (rx_done)         m_busy <= 1'b0;
      if (!m_busy)              sck_lvl <= f_ckp;
      else if (m_tick)          sck_lvl <= ~sck_lvl;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxbuf    <= '0;
      buf_full <= 1'b0;
    end else if (store) begin
      rxbuf    <= rx_data;
      buf_full <= 1'b1;
    end else if (buf_rd) begin
      buf_full <= 1'b0;
    end
  end

  assign ctl_rdata = {f_wcol, f_ovf, f_en, f_ckp, f_mode};
  assign buf_rdata = rxbuf;
  assign port_en   = en_ok;
  assign sck_o     = master_m ? sck_lvl : f_ckp;
  assign sck_oe    = en_ok && master_m;
  assign sdo_o     = sh_sdo;
  assign sdo_oe    = en_ok && (master_m || ss_ok);
endmodule

// File: rtl/spi_port_chk.sv
module spi_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       ctl_wr,
  input logic       buf_wr,
  input logic       buf_rd,
  input logic [7:0] ctl_rdata,
  input logic [7:0] buf_rdata,
  input logic       buf_full,
  input logic       sck_oe,
  input logic       sdo_oe,
  input logic       xfer_active,
  input logic       rx_done,
  input logic       slave_m
);
  p_full_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rx_done |=> buf_full);

  p_wcol_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (buf_wr && xfer_active) |=> ctl_rdata[7]);

  p_ovf_keep_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_done && slave_m && buf_full && !buf_rd) |=> (ctl_rdata[6] && $stable(buf_rdata)));

  p_no_overflow_r7: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(ctl_rdata[6]) && !$past(ctl_wr)) |-> $past(slave_m));

  p_sticky_wcol_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[7] && !ctl_wr) |=> ctl_rdata[7]);

  p_sticky_ovf_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_rdata[6] && !ctl_wr) |=> ctl_rdata[6]);

  p_pins_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
    !ctl_rdata[5] |-> (!sck_oe && !sdo_oe));
endmodule

bind spi_port spi_port_chk u_chk (
  .clk(clk), .rst_n(rst_n), .ctl_wr(ctl_wr), .buf_wr(buf_wr), .buf_rd(buf_rd),
  .ctl_rdata(ctl_rdata), .buf_rdata(buf_rdata), .buf_full(buf_full),
  .sck_oe(sck_oe), .sdo_oe(sdo_oe), .xfer_active(xfer_active),
  .rx_done(rx_done), .slave_m(slave_m)
);

// File: tb/spi_port_bench.sv
module spi_port_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic tmr_pulse = 1'b0;
  logic ctl_wr = 1'b0;
  logic [7:0] ctl_wdata = '0;
  logic [7:0] ctl_rdata;
  logic buf_wr = 1'b0;
  logic [7:0] buf_wdata = '0;
  logic buf_rd = 1'b0;
  logic [7:0] buf_rdata;
  logic buf_full, port_en, sck_o, sck_oe, sdo_o, sdo_oe;
  logic sck_drv = 1'b0;
  logic sdi_drv = 1'b0;
  logic ss_n_drv = 1'b1;
  logic loop = 1'b0;
  logic sdi_i;
  int checks = 0;
  int fails = 0;
  int cyc = 0;
  int tcnt = 0;

  always #5 clk = ~clk;

  assign sdi_i = loop ? sdo_o : sdi_drv;

  spi_port u_spi_port (
    .clk(clk), .rst_n(rst_n), .tmr_pulse(tmr_pulse), .ctl_wr(ctl_wr),
    .ctl_wdata(ctl_wdata), .ctl_rdata(ctl_rdata), .buf_wr(buf_wr),
    .buf_wdata(buf_wdata), .buf_rd(buf_rd), .buf_rdata(buf_rdata),
    .buf_full(buf_full), .port_en(port_en), .sck_i(sck_drv), .sck_o(sck_o),
    .sck_oe(sck_oe), .sdi_i(sdi_i), .sdo_o(sdo_o), .sdo_oe(sdo_oe),
    .ss_n_i(ss_n_drv)
  );

  // timer model: one-cycle pulse every 5 clocks
  always @(negedge clk) begin
    tcnt <= (tcnt == 4) ? 0 : tcnt + 1;
    tmr_pulse <= (tcnt == 4);
  end

  task automatic report;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  always @(negedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      fails++;
      $display("FAIL watchdog: actual=%0d cycles expected=<150000", cyc);
      report();
      $finish;
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic wr_ctl(input logic [7:0] v);
    @(negedge clk); ctl_wdata = v; ctl_wr = 1'b1;
    @(negedge clk); ctl_wr = 1'b0;
  endtask

  task automatic wr_buf(input logic [7:0] v);
    @(negedge clk); buf_wdata = v; buf_wr = 1'b1;
    @(negedge clk); buf_wr = 1'b0;
  endtask

  task automatic rd_buf;
    @(negedge clk); buf_rd = 1'b1;
    @(negedge clk); buf_rd = 1'b0;
  endtask

  task automatic wait_full(output bit ok);
    ok = 1'b0;
    for (int i = 0; i < 3000; i++) begin
      if (buf_full) begin ok = 1'b1; break; end
      @(negedge clk);
    end
  endtask

  // cycles between two successive leading SCK edges (leading leaves ckp)
  task automatic measure(input bit ckp, output int n);
    int g;
    g = 0;
    while (sck_o == ckp && g < 5000) begin @(negedge clk); g++; end
    n = 0;
    do begin @(negedge clk); n++; end while (sck_o != ckp && n < 5000);
    while (sck_o == ckp && n < 5000) begin @(negedge clk); n++; end
  endtask

  task automatic slave_bit(input bit b, input bit ckp, output bit seen);
    sdi_drv = b;
    idle(2);
    seen = sdo_o;
    sck_drv = ~ckp; idle(8);
    sck_drv = ckp;  idle(8);
  endtask

  task automatic slave_byte(input logic [7:0] tx, input bit ckp, output logic [7:0] got);
    bit s;
    for (int i = 7; i >= 0; i--) begin
      slave_bit(tx[i], ckp, s);
      got[i] = s;
    end
    idle(8);
  endtask

  task automatic t_reset;
    chk(ctl_rdata == 8'h00, "R1 ctl", ctl_rdata, 0);
    chk(!buf_full && !sck_oe && !sdo_oe && !port_en, "R1 status/pins",
        {buf_full, sck_oe, sdo_oe, port_en}, 0);
  endtask

  task automatic t_master(input logic [3:0] mode, input int exp_per, input logic [7:0] tx);
    int n; bit ok;
    loop = 1'b1;
    wr_ctl({4'b0010, mode});
    chk(sck_oe && sdo_oe && port_en, "R2 master pins on", {sck_oe, sdo_oe}, 3);
    wr_buf(tx);
    measure(1'b0, n);
    chk(n == exp_per, "R2 sck period", n, exp_per);
    wait_full(ok);
    chk(ok && buf_rdata == tx, "R4 loopback byte", buf_rdata, tx);
    rd_buf();
    chk(!buf_full, "R4 read clears full", buf_full, 0);
    loop = 1'b0;
  endtask

  task automatic t_polarity;
    int n; bit ok;
    loop = 1'b1;
    wr_ctl(8'h30);
    idle(2);
    chk(sck_o == 1'b1, "R3 idle high", sck_o, 1);
    wr_buf(8'h5A);
    measure(1'b1, n);
    chk(n == 4, "R3 period with high idle", n, 4);
    wait_full(ok);
    chk(ok && buf_rdata == 8'h5A, "R3 data with high idle", buf_rdata, 8'h5A);
    idle(2);
    chk(sck_o == 1'b1, "R3 returns to idle high", sck_o, 1);
    rd_buf();
    loop = 1'b0;
  endtask

  task automatic t_collision;
    bit ok;
    loop = 1'b1;
    wr_ctl(8'h21);
    wr_buf(8'h96);
    idle(20);
    wr_buf(8'h11);
    chk(ctl_rdata[7], "R5 collision flag", ctl_rdata, 8'hA1);
    wait_full(ok);
    chk(ok && buf_rdata == 8'h96, "R5 original byte kept", buf_rdata, 8'h96);
    idle(10);
    chk(ctl_rdata[7], "R8 collision sticky", ctl_rdata, 8'hA1);
    wr_ctl(8'h21);
    chk(ctl_rdata == 8'h21, "R8 collision cleared", ctl_rdata, 8'h21);
    rd_buf();
    loop = 1'b0;
  endtask

  task automatic t_master_no_ovf;
    bit ok;
    loop = 1'b1;
    wr_ctl(8'h20);
    wr_buf(8'h81); wait_full(ok); idle(4);
    wr_buf(8'h7E); idle(4);
    for (int i = 0; i < 200 && u_spi_port.sck_oe && buf_rdata != 8'h7E; i++) @(negedge clk);
    idle(4);
    chk(buf_rdata == 8'h7E, "R7 master overwrites", buf_rdata, 8'h7E);
    chk(!ctl_rdata[6], "R7 no overflow in master", ctl_rdata[6], 0);
    rd_buf();
    loop = 1'b0;
  endtask

  task automatic t_slave;
    logic [7:0] got;
    ss_n_drv = 1'b1;
    wr_ctl(8'h25);
    idle(4);
    chk(sdo_oe && !sck_oe, "R11 sdo driven with ss high", {sdo_oe, sck_oe}, 2);
    wr_buf(8'h3C);
    slave_byte(8'hA5, 1'b0, got);
    chk(got == 8'h3C, "R3 sdo MSB first", got, 8'h3C);
    chk(buf_full && buf_rdata == 8'hA5, "R11 received with ss ignored", buf_rdata, 8'hA5);
    rd_buf();
    slave_byte(8'h11, 1'b0, got);
    chk(buf_full && buf_rdata == 8'h11, "R4 slave first byte", buf_rdata, 8'h11);
    slave_byte(8'h22, 1'b0, got);
    chk(ctl_rdata[6], "R6 overflow set", ctl_rdata, 8'h65);
    chk(buf_rdata == 8'h11, "R6 buffer keeps first byte", buf_rdata, 8'h11);
    idle(20);
    chk(ctl_rdata[6], "R8 overflow sticky", ctl_rdata, 8'h65);
    wr_ctl(8'h25);
    chk(!ctl_rdata[6], "R8 overflow cleared", ctl_rdata, 8'h25);
    rd_buf();
  endtask

  task automatic t_ss;
    logic [7:0] got; bit s;
    ss_n_drv = 1'b1;
    wr_ctl(8'h24);
    idle(4);
    chk(!sdo_oe, "R10 sdo released while deselected", sdo_oe, 0);
    ss_n_drv = 1'b0; idle(4);
    chk(sdo_oe, "R10 sdo driven while selected", sdo_oe, 1);
    slave_bit(1'b1, 1'b0, s); slave_bit(1'b1, 1'b0, s); slave_bit(1'b1, 1'b0, s);
    ss_n_drv = 1'b1; idle(6);
    ss_n_drv = 1'b0; idle(6);
    slave_byte(8'hC3, 1'b0, got);
    chk(buf_full && buf_rdata == 8'hC3, "R10 framing restarts", buf_rdata, 8'hC3);
    rd_buf();
    ss_n_drv = 1'b1;
  endtask

  task automatic t_disable;
    wr_ctl(8'h00);
    wr_buf(8'h55); idle(100);
    chk(!port_en && !sck_oe && !sdo_oe, "R9 pins released", {port_en, sck_oe, sdo_oe}, 0);
    chk(!buf_full, "R9 no transfer when off", buf_full, 0);
    wr_ctl(8'h26);
    wr_buf(8'h55); idle(100);
    chk(!port_en && !sck_oe && !sdo_oe, "R12 reserved mode pins", {port_en, sck_oe, sdo_oe}, 0);
    chk(!buf_full, "R12 reserved mode no transfer", buf_full, 0);
  endtask

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(2);
    t_reset();
    t_master(4'b0000, 4,  8'hA7);
    t_master(4'b0001, 16, 8'h3E);
    t_master(4'b0010, 64, 8'hC1);
    t_master(4'b0011, 10, 8'h69);
    t_polarity();
    t_collision();
    t_master_no_ovf();
    t_slave();
    t_ss();
    t_disable();
    report();
    $finish;
  end
endmodule